// File: doc/BRIEF.md
# Watchdog Frequency Fall-back Controller

This block keeps a system clock generator's frequency-select code under watchdog supervision. Software programs a target code, a fall-back code, a watchdog interval and an enable through a small byte-wide register port. It must then strobe a kick input at regular intervals to show that the system still runs. If the kicks stop, the block holds an active-low system reset low for a fixed time. On each such reset it moves to a more conservative frequency source.

Recovery has three levels. At the normal level the code comes from the target register, or from the strap value, according to a source-select bit. After the first watchdog reset the block uses the programmed fall-back code. After any further reset it uses the code captured from the strap pins at power-on. The level survives watchdog resets. Only a power-on reset or a kick accepted while the watchdog is enabled returns it to normal. Time is measured in ticks of `TICK_DIV` clock cycles, and the reset pulse lasts `PULSE_CYC` cycles. The defaults give 1 ms ticks and a 500 ms pulse at 33 MHz.

Top module: `wdt_freq_fallback`

## Requirements
- R1: On the first clock after `por_n` is released, the block captures `strap_code` and drives it on `freq_sel`. Later changes of `strap_code` have no effect until the next power-on reset.
- R2: A target write (address 0) outside a reset pulse drives `freq_sel` on the next cycle. At the normal level the value is the written code when bit 5 is 1, and the captured strap code when bit 5 is 0.
- R3: Register layout, written with `cfg_we`: address 0 holds the target code in bits 4:0 and the source select in bit 5. Address 1 holds the fall-back code in bits 7:3. Address 2 holds the interval in bits 4:0 (bit 0 is the LSB) and the enable in bit 7.
- R4: With the enable set and an interval N > 0, `sys_rst_n` goes low N×`TICK_DIV` cycles after the last timer reload. A reload is caused by a target write, an address-2 write, an accepted kick, or the end of a reset pulse.
- R5: `sys_rst_n` stays low for exactly `PULSE_CYC` cycles. A new interval starts on the cycle it returns high.
- R6: A timeout at the normal level moves to the fall-back level. `freq_sel` shows the fall-back code from the first cycle of the pulse.
- R7: A timeout at the fall-back level or the strap level moves to, or stays at, the strap level. `freq_sel` shows the captured strap code.
- R8: A kick while the enable is set and no pulse is active reloads the timer and returns the level to normal. `freq_sel` does not change at the kick.
- R9: A kick while the enable is clear, or during a reset pulse, changes neither the level nor the timer.
- R10: With the enable clear or the interval 0, no timeout occurs.
- R11: `freq_sel` changes only on a target write outside a pulse or on the first cycle of a pulse. At a non-normal level, a target write drives that level's code rather than the target code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| strap_code | input | 5 | Frequency code from the strap pins |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| kick | input | 1 | Software alive strobe |
| freq_sel | output | 5 | Active frequency-select code |
| sys_rst_n | output | 1 | Active-low watchdog system reset |

## Verification
Several input patterns are applied, and each separates a different kind of fault:
- Writes with the source select set and clear tell the target path apart from the strap path.
- A disabled watchdog and a zero interval each expose a timer that runs when it should be idle.
- A steady kick train followed by silence measures the exact interval length and the exact pulse length.
- Consecutive timeouts without kicks separate the first escalation step from the second.
- Kicks given while the watchdog is disabled or during a pulse, followed by a further timeout, show whether the block wrongly cleared the level.
- A bench-side behavioural model checks `freq_sel` and `sys_rst_n` on every clock.

// File: rtl/wdt_freq_fallback.sv
module wdt_freq_fallback #(
  parameter int TICK_DIV  = 33000,
  parameter int PULSE_CYC = 16500000
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic [4:0] strap_code,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       kick,
  output logic [4:0] freq_sel,
  output logic       sys_rst_n
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int QW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) + 1 : 1;

  typedef enum logic [1:0] {LV_NORM, LV_FB, LV_STRAP} lvl_t;

  logic [4:0] tgt_q, fb_q, ivl_q, strap_q, freq_q, ela_q;
  logic       sel_q, en_q, latched_q, rst_q;
  lvl_t       lvl_q, lvl_nx;
  logic [PW-1:0] pre_q;
  logic [QW-1:0] pw_q;

  wire wr_tgt = latched_q && cfg_we && cfg_addr == 2'd0;
  wire wr_fb  = latched_q && cfg_we && cfg_addr == 2'd1;
  wire wr_wd  = latched_q && cfg_we && cfg_addr == 2'd2;

  wire kick_ok  = latched_q && rst_q && kick && en_q;
  wire reload   = latched_q && rst_q && (wr_tgt || wr_wd || kick_ok);
  wire running  = latched_q && rst_q && en_q && ivl_q != 5'd0;
  wire tick_end = pre_q == PW'(TICK_DIV - 1);
  wire expire   = running && !reload && tick_end && ela_q == ivl_q - 5'd1;

  wire [4:0] tgt_nx = wr_tgt ? cfg_wdata[4:0] : tgt_q;
  wire       sel_nx = wr_tgt ? cfg_wdata[5]   : sel_q;
  wire [4:0] fb_nx  = wr_fb  ? cfg_wdata[7:3] : fb_q;

  always_comb begin
    lvl_nx = lvl_q;
    if (kick_ok)
      lvl_nx = LV_NORM;
    else if (expire)
      lvl_nx = (lvl_q == LV_NORM) ? LV_FB : LV_STRAP;
  end

  logic [4:0] code_nx;
  always_comb begin
    case (lvl_nx)
      LV_NORM: code_nx = sel_nx ? tgt_nx : strap_q;
      LV_FB:   code_nx = fb_nx;
      default: code_nx = strap_q;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      latched_q <= 1'b0;
      strap_q   <= 5'd0;
      tgt_q     <= 5'd0;
      sel_q     <= 1'b0;
      fb_q      <= 5'd0;
      ivl_q     <= 5'd0;
      en_q      <= 1'b0;
      lvl_q     <= LV_NORM;
      freq_q    <= 5'd0;
    end else if (!latched_q) begin
      latched_q <= 1'b1;
      strap_q   <= strap_code;
      freq_q    <= strap_code;
    end else begin
      tgt_q <= tgt_nx;
      sel_q <= sel_nx;
      fb_q  <= fb_nx;
      if (wr_wd) begin
        ivl_q <= cfg_wdata[4:0];
        en_q  <= cfg_wdata[7];
      end
      lvl_q <= lvl_nx;
      if (expire || (wr_tgt && rst_q))
        freq_q <= code_nx;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pre_q <= '0;
      ela_q <= 5'd0;
    end else if (!running || reload || expire) begin
      pre_q <= '0;
      ela_q <= 5'd0;
    end else if (tick_end) begin
      pre_q <= '0;
      ela_q <= ela_q + 5'd1;
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_q <= 1'b1;
      pw_q  <= '0;
    end else if (expire) begin
      rst_q <= 1'b0;
      pw_q  <= '0;
    end else if (!rst_q) begin
      if (pw_q == QW'(PULSE_CYC - 1))
        rst_q <= 1'b1;
      else
        pw_q <= pw_q + QW'(1);
    end
  end

  assign freq_sel  = freq_q;
  assign sys_rst_n = rst_q;

  assert_hold_strap_R1: assert property (@(posedge clk) disable iff (!por_n)
    (latched_q && $past(latched_q)) |-> $stable(strap_q));

  assert_freq_event_R11: assert property (@(posedge clk) disable iff (!por_n)
    ($past(latched_q) && !$stable(freq_sel)) |-> ($fell(sys_rst_n) || $past(wr_tgt && rst_q)));

  assert_pulse_bound_R5: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |-> pw_q < QW'(PULSE_CYC));

  assert_needs_enable_R10: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst_n) |-> ($past(en_q) && $past(ivl_q) != 5'd0));

  assert_first_step_R6: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(sys_rst_n) && $past(lvl_q) == LV_NORM) |-> (lvl_q == LV_FB && freq_sel == fb_q));

  assert_second_step_R7: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(sys_rst_n) && $past(lvl_q) != LV_NORM) |-> (lvl_q == LV_STRAP && freq_sel == strap_q));

  assert_clear_by_kick_R8: assert property (@(posedge clk) disable iff (!por_n)
    (lvl_q == LV_NORM && $past(lvl_q) != LV_NORM) |-> $past(kick && en_q && rst_q));
endmodule

// File: tb/wdt_freq_fallback_bench.sv
module wdt_freq_fallback_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK  = 4;
  localparam int PULSE = 10;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic [4:0] strap_code = 5'h0B;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic kick = 1'b0;
  logic [4:0] freq_sel;
  logic sys_rst_n;

  int n_checks = 0;
  int n_fail = 0;
  string cur = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_freq_fallback #(.TICK_DIV(TICK), .PULSE_CYC(PULSE)) u_wdt_freq_fallback (
    .clk(clk), .por_n(por_n), .strap_code(strap_code), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .kick(kick),
    .freq_sel(freq_sel), .sys_rst_n(sys_rst_n));

  // behavioural reference
  logic [4:0] m_tgt, m_fb, m_ivl, m_strap, m_freq;
  logic m_sel, m_en, m_lat, m_rst;
  int m_lvl, m_cnt, m_pcnt;

  function automatic logic [4:0] mcode(int lv);
    if (lv == 0) return m_sel ? m_tgt : m_strap;
    if (lv == 1) return m_fb;
    return m_strap;
  endfunction

  always @(posedge clk) begin
    logic kok, run, rl, tw;
    if (!por_n) begin
      m_tgt = 0; m_fb = 0; m_ivl = 0; m_strap = 0; m_freq = 0;
      m_sel = 0; m_en = 0; m_lat = 0; m_rst = 1; m_lvl = 0; m_cnt = 0; m_pcnt = 0;
    end else if (!m_lat) begin
      m_lat = 1; m_strap = strap_code; m_freq = strap_code;
    end else begin
      kok = kick && m_en && m_rst;
      run = m_en && m_ivl != 0 && m_rst;
      tw  = cfg_we && cfg_addr == 2'd0;
      rl  = m_rst && (tw || (cfg_we && cfg_addr == 2'd2) || kok);
      if (tw) begin m_tgt = cfg_wdata[4:0]; m_sel = cfg_wdata[5]; end
      if (cfg_we && cfg_addr == 2'd1) m_fb = cfg_wdata[7:3];
      if (cfg_we && cfg_addr == 2'd2) begin m_ivl = cfg_wdata[4:0]; m_en = cfg_wdata[7]; end
      if (kok) m_lvl = 0;
      if (!m_rst) begin
        if (m_pcnt == 1) begin m_rst = 1; m_cnt = 0; end
        else m_pcnt--;
      end else if (rl || !run) begin
        m_cnt = 0;
        if (tw) m_freq = mcode(m_lvl);
      end else begin
        m_cnt++;
        if (m_cnt == int'(m_ivl) * TICK) begin
          m_lvl = (m_lvl == 0) ? 1 : 2;
          m_freq = mcode(m_lvl);
          m_rst = 0; m_pcnt = PULSE; m_cnt = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (por_n && m_lat) begin
      n_checks++;
      if (freq_sel !== m_freq || sys_rst_n !== m_rst) begin
        n_fail++;
        $display("FAIL %s model: freq_sel=%h rst_n=%b expected freq_sel=%h rst_n=%b",
                 cur, freq_sel, sys_rst_n, m_freq, m_rst);
      end
    end
  end

  task automatic check(string tag, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_kick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic until_low(output int n);
    n = 0;
    while (sys_rst_n && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic until_high(output int n);
    n = 0;
    while (!sys_rst_n && n < 1000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int n;
    cycles(3);
    check("R1 reset rst_n", int'(sys_rst_n), 1);
    por_n = 1'b1;
    cycles(2);
    cur = "R1";
    check("R1 strap captured", int'(freq_sel), 'h0B);
    strap_code = 5'h1F;
    cycles(3);
    check("R1 strap change ignored", int'(freq_sel), 'h0B);

    cur = "R3";
    wr(2'd1, 8'h07 << 3);
    cur = "R2";
    wr(2'd0, 8'h32);
    check("R2 target selected", int'(freq_sel), 'h12);
    wr(2'd0, 8'h12);
    check("R2 strap selected", int'(freq_sel), 'h0B);
    wr(2'd0, 8'h32);

    cur = "R10";
    wr(2'd2, 8'h03);
    cycles(40);
    check("R10 disabled no timeout", int'(sys_rst_n), 1);
    wr(2'd2, 8'h80);
    cycles(40);
    check("R10 zero interval no timeout", int'(sys_rst_n), 1);

    cur = "R8";
    wr(2'd2, 8'h83);
    for (int i = 0; i < 5; i++) begin cycles(7); do_kick(); end
    check("R8 kicks prevent reset", int'(sys_rst_n), 1);
    cur = "R4";
    until_low(n);
    check("R4 interval length", n, 3 * TICK);
    check("R6 fall-back code", int'(freq_sel), 'h07);
    cur = "R5";
    until_high(n);
    check("R5 pulse length", n, PULSE);
    cur = "R7";
    until_low(n);
    check("R4 interval after pulse", n, 3 * TICK);
    check("R7 strap code", int'(freq_sel), 'h0B);
    until_high(n);
    until_low(n);
    check("R7 stays strap", int'(freq_sel), 'h0B);
    until_high(n);

    cur = "R11";
    wr(2'd0, 8'h35);
    check("R11 target write at strap level", int'(freq_sel), 'h0B);
    cur = "R8";
    do_kick();
    check("R8 kick keeps freq", int'(freq_sel), 'h0B);
    wr(2'd0, 8'h32);
    check("R8 normal after kick", int'(freq_sel), 'h12);
    until_low(n);
    check("R8 escalation restarts at fall-back", int'(freq_sel), 'h07);

    cur = "R9";
    cycles(2);
    do_kick();
    until_high(n);
    until_low(n);
    check("R9 kick in pulse ignored", int'(freq_sel), 'h0B);
    until_high(n);
    wr(2'd2, 8'h03);
    do_kick();
    wr(2'd2, 8'h83);
    until_low(n);
    check("R9 disabled kick ignored", int'(freq_sel), 'h0B);
    until_high(n);
    cycles(5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule